// File: doc/BRIEF.md
# Instruction Suppression Sequencer

This block sits between instruction decode and execute in a small 8-bit processor model. Each decoded instruction arrives with its opcode class, its destination register number, the number of cycles it occupies, a flag telling whether it was reached through a taken jump, and the outcome of its own skip test as evaluated by the datapath. The sequencer decides, one instruction at a time, whether that instruction takes effect or is turned into a no-operation that still uses up its full cycle count.

There are two reasons to suppress an instruction. The first is conditional skipping: an executed instruction whose skip test comes out true cancels the next instruction. The second is stacking: in a back-to-back run of move-immediate instructions that all target the same register, only the first one writes. This lets software fall through a table of move-immediates. A jump into the middle of the table loads that entry's value, and the entries after it pass by without effect. A taken jump clears the stacking state, so the instruction at the jump target always executes.

A two-state machine controls the slot. In `SLOT_IDLE` the block is ready to accept an instruction. An accepted instruction that needs more than one cycle takes the `IDLE->HOLD` transition. In `SLOT_HOLD` the busy counter counts down, and when it reaches zero the `HOLD->IDLE` transition is taken. An instruction that needs one cycle, or zero cycles, stays on the `IDLE->IDLE` path. Skip-pending and stacking-run state live in a decision unit beside the machine.

Top module: `insn_supp_seq`

## Requirements
- R1: After reset, `insn_ready` is 1, and `issue`, `exec_en`, `supp_kind` and `busy_cnt` are 0. No skip is pending and no stacking run is active, so the first move-immediate after reset executes.
- R2: An instruction is accepted at the rising edge at which `insn_valid` and `insn_ready` are both 1. `issue` is 1 for exactly the cycle that follows that edge and is 0 in every other cycle.
- R3: After an instruction with cycle count N is issued, `busy_cnt` reads max(N,1)-1 and decreases by one each cycle. `insn_ready` is 1 exactly when `busy_cnt` is 0, so each slot lasts max(N,1) cycles. This holds whether the instruction executes or is suppressed.
- R4: An instruction that executes and whose `insn_skip_cond` is 1 causes the next accepted instruction to be suppressed with `supp_kind` = 1 (skip).
- R5: The `insn_skip_cond` of a suppressed instruction is ignored. It never causes the instruction after it to be suppressed.
- R6: A move-immediate (`insn_class` = 1) whose destination equals that of the move-immediate that opened the current run is suppressed with `supp_kind` = 2 (stack). The run stays active.
- R7: A run is opened by an executed move-immediate. It ends at the first instruction that is not a move-immediate, or that is a move-immediate to a different destination. That instruction executes normally, and a move-immediate to a different destination opens a new run.
- R8: An instruction with `insn_redirect` = 1 (the target of a taken jump) is never stack-suppressed, even if it would continue the run. It executes and restarts the run state.
- R9: A pending skip takes priority over both stacking and redirect. An instruction suppressed by a skip also ends any active stacking run.
- R10: On the issue cycle, `exec_en` is 1 exactly when `supp_kind` = 0. Outside the issue cycle, both are 0. `supp_kind` code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | A decoded instruction is presented |
| insn_ready | output | 1 | The slot is free and an instruction can be accepted |
| insn_class | input | 2 | Opcode class: 0 other, 1 move-immediate, 2 branch, 3 skip test |
| insn_dest | input | DEST_W (3) | Destination register number |
| insn_cycles | input | CYC_W (4) | Cycle count of the instruction (0 is treated as 1) |
| insn_redirect | input | 1 | The instruction was reached by a taken jump |
| insn_skip_cond | input | 1 | The instruction's own skip test is true |
| issue | output | 1 | One-cycle pulse after an instruction is accepted |
| exec_en | output | 1 | The issued instruction takes effect |
| supp_kind | output | 2 | Suppression reason: 0 none, 1 skip, 2 stack |
| busy_cnt | output | CYC_W (4) | Cycles still held by the current slot |

## Verification
The assertions check the following on every cycle:
- one issue pulse per accept;
- the busy counter stepping down by one and agreeing with `insn_ready`;
- a suppressed instruction never leaving a skip pending;
- an executed move-immediate capturing its destination;
- a skip-suppressed instruction ending the run.

Some behaviours depend on sequences of instructions, and only the bench's scenarios can show them:
- whether a given instruction executes or is suppressed;
- the priority order between skip, redirect and stacking;
- a fall-through move-immediate table entered in the middle;
- that reset clears the run state.

The bench covers these with a near-exhaustive sweep over pairs of class, destination, redirect and skip outcome, checked against its own reference model.

// File: rtl/insn_supp_pkg.sv
`timescale 1ns/1ps
package insn_supp_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_MOVI   = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_TEST   = 2'd3
    } insn_cls_e;

    typedef enum logic [1:0] {
        SUP_NONE  = 2'd0,
        SUP_SKIP  = 2'd1,
        SUP_STACK = 2'd2
    } supp_kind_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HOLD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/insn_supp_decide.sv
`timescale 1ns/1ps
module insn_supp_decide
    import insn_supp_pkg::*;
#(
    parameter int DEST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        cls,
    input  logic [DEST_W-1:0] dest,
    input  logic              redirect,
    input  logic              skip_cond,
    output supp_kind_e        kind
);

    logic              skip_pend;
    logic              run_valid;
    logic [DEST_W-1:0] run_dest;
    logic              is_movi;
    logic              continues_run;

    assign is_movi       = (insn_cls_e'(cls) == CLS_MOVI);
    assign continues_run = is_movi && run_valid && (dest == run_dest) && !redirect;

    // Priority order: pending skip first, then stacking.
    always_comb begin
        if (skip_pend) begin
            kind = SUP_SKIP;
        end else if (continues_run) begin
            kind = SUP_STACK;
        end else begin
            kind = SUP_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_pend <= 1'b0;
            run_valid <= 1'b0;
            run_dest  <= '0;
        end else if (accept) begin
            unique case (kind)
                SUP_SKIP: begin
                    skip_pend <= 1'b0;
                    run_valid <= 1'b0;
                end
                SUP_STACK: begin
                    skip_pend <= 1'b0;
                end
                default: begin
                    skip_pend <= skip_cond;
                    run_valid <= is_movi;
                    if (is_movi) begin
                        run_dest <= dest;
                    end
                end
            endcase
        end
    end

    // R5
    skip_not_chained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind != SUP_NONE) |=> !skip_pend);

    // R7
    run_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == SUP_NONE && is_movi) |=> (run_valid && run_dest == $past(dest)));

    // R9
    skip_breaks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == SUP_SKIP) |=> !run_valid);

endmodule

// File: rtl/insn_supp_timer.sv
`timescale 1ns/1ps
module insn_supp_timer #(
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] load_val,
    output logic [CYC_W-1:0] cnt
);

    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - ONE;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/insn_supp_seq.sv
`timescale 1ns/1ps
module insn_supp_seq
    import insn_supp_pkg::*;
#(
    parameter int DEST_W = 3,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    output logic              insn_ready,
    input  logic [1:0]        insn_class,
    input  logic [DEST_W-1:0] insn_dest,
    input  logic [CYC_W-1:0]  insn_cycles,
    input  logic              insn_redirect,
    input  logic              insn_skip_cond,
    output logic              issue,
    output logic              exec_en,
    output logic [1:0]        supp_kind,
    output logic [CYC_W-1:0]  busy_cnt
);

    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);

    slot_state_e state_q, state_d;
    supp_kind_e  kind_w;
    logic        accept;

    assign insn_ready = (state_q == SLOT_IDLE);
    assign accept     = insn_valid && insn_ready;

    insn_supp_decide #(.DEST_W(DEST_W)) decide_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cls       (insn_class),
        .dest      (insn_dest),
        .redirect  (insn_redirect),
        .skip_cond (insn_skip_cond),
        .kind      (kind_w)
    );

    insn_supp_timer #(.CYC_W(CYC_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (insn_cycles),
        .cnt      (busy_cnt)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (accept && insn_cycles > ONE) state_d = SLOT_HOLD;
            SLOT_HOLD: if (busy_cnt == ONE)              state_d = SLOT_IDLE;
            default:                                     state_d = SLOT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue     <= 1'b0;
            exec_en   <= 1'b0;
            supp_kind <= SUP_NONE;
        end else begin
            issue     <= accept;
            exec_en   <= accept && (kind_w == SUP_NONE);
            supp_kind <= accept ? kind_w : SUP_NONE;
        end
    end

    // R2
    issue_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> issue);

    // R2
    no_spurious_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !issue);

    // R3
    ready_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_ready == (busy_cnt == '0));

    // R10
    quiet_outside_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |-> (!exec_en && supp_kind == 2'd0));

    // R10
    kind_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supp_kind != 2'd3);

endmodule

// File: tb/insn_supp_seq_tb.sv
`timescale 1ns/1ps
module insn_supp_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_valid = 1'b0;
    logic       insn_ready;
    logic [1:0] insn_class = 2'd0;
    logic [2:0] insn_dest = 3'd0;
    logic [3:0] insn_cycles = 4'd1;
    logic       insn_redirect = 1'b0;
    logic       insn_skip_cond = 1'b0;
    logic       issue;
    logic       exec_en;
    logic [1:0] supp_kind;
    logic [3:0] busy_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    bit       m_skip = 1'b0;
    bit       m_run  = 1'b0;
    bit [2:0] m_dest = 3'd0;
    bit       m_prev_supp_sk = 1'b0;

    always #10 clk = ~clk;

    insn_supp_seq #(.DEST_W(3), .CYC_W(4)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .insn_valid     (insn_valid),
        .insn_ready     (insn_ready),
        .insn_class     (insn_class),
        .insn_dest      (insn_dest),
        .insn_cycles    (insn_cycles),
        .insn_redirect  (insn_redirect),
        .insn_skip_cond (insn_skip_cond),
        .issue          (issue),
        .exec_en        (exec_en),
        .supp_kind      (supp_kind),
        .busy_cnt       (busy_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        insn_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_skip = 1'b0;
        m_run  = 1'b0;
        m_prev_supp_sk = 1'b0;
        @(negedge clk);
        chk(insn_ready == 1'b1, "R1 ready", int'(insn_ready), 1);
        chk(issue == 1'b0 && exec_en == 1'b0, "R1 issue/exec", int'({issue, exec_en}), 0);
        chk(supp_kind == 2'd0 && busy_cnt == 4'd0, "R1 kind/busy",
            int'({supp_kind, busy_cnt}), 0);
    endtask

    task automatic run_insn(input int c, input int d, input int n, input bit r, input bit s);
        int    exp_kind;
        int    exp_slot;
        int    cnt;
        string tag;
        bit    would_stack;
        would_stack = (c == 1) && m_run && (3'(d) == m_dest) && !r;
        if (m_skip) begin
            exp_kind = 1;
            tag = would_stack ? "R9" : (r ? "R9" : "R4");
            m_skip = 1'b0;
            m_run  = 1'b0;
            m_prev_supp_sk = s;
        end else if (would_stack) begin
            exp_kind = 2;
            tag = "R6";
            m_prev_supp_sk = s;
        end else begin
            exp_kind = 0;
            tag = m_prev_supp_sk ? "R5" : (r ? "R8" : "R7");
            m_skip = s;
            m_run  = (c == 1);
            if (c == 1) m_dest = 3'(d);
            m_prev_supp_sk = 1'b0;
        end
        exp_slot = (n == 0) ? 1 : n;
        @(negedge clk);
        insn_valid     = 1'b1;
        insn_class     = 2'(c);
        insn_dest      = 3'(d);
        insn_cycles    = 4'(n);
        insn_redirect  = r;
        insn_skip_cond = s;
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(issue == 1'b1, "R2 issue", int'(issue), 1);
        chk(int'(supp_kind) == exp_kind, tag, int'(supp_kind), exp_kind);
        chk(exec_en == (exp_kind == 0), "R10 exec", int'(exec_en), int'(exp_kind == 0));
        chk(int'(busy_cnt) == exp_slot - 1, "R3 busy", int'(busy_cnt), exp_slot - 1);
        cnt = 1;
        while (!insn_ready && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (issue) chk(1'b0, "R2 extra issue", 1, 0);
        end
        chk(cnt == exp_slot, "R3 slot", cnt, exp_slot);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first move-immediate executes, second stacks
        run_insn(1, 1, 2, 0, 0);
        run_insn(1, 1, 2, 0, 0);
        // fall-through table: enter at entry two via jump
        run_insn(2, 0, 3, 0, 0);
        run_insn(1, 4, 1, 1, 0);   // R8 target executes
        run_insn(1, 4, 1, 0, 0);   // R6 stacked
        run_insn(1, 4, 1, 0, 0);   // R6 stacked
        run_insn(0, 0, 2, 0, 0);   // R7 run ends
        run_insn(1, 4, 1, 0, 0);   // R7 new run executes
        run_insn(1, 5, 1, 0, 0);   // R7 different dest executes
        // R4 then R5: skip suppresses a test whose own skip is ignored
        run_insn(3, 0, 2, 0, 1);
        run_insn(3, 0, 2, 0, 1);
        run_insn(0, 0, 0, 0, 0);
        // mid-run reset clears the run state (R1)
        run_insn(1, 2, 1, 0, 0);
        do_reset();
        run_insn(1, 2, 1, 0, 0);
        // near-exhaustive pair sweep
        for (int a = 0; a < 4; a++)
            for (int da = 0; da < 2; da++)
                for (int b = 0; b < 4; b++)
                    for (int db = 0; db < 2; db++)
                        for (int rr = 0; rr < 2; rr++)
                            for (int sk = 0; sk < 2; sk++) begin
                                run_insn(a, da, (a + b) % 4, 1'(rr & da), 1'(sk));
                                run_insn(b, db, (da + db + sk) % 3, 1'(rr), 1'(sk ^ db));
                            end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule